// File: doc/BRIEF.md
# Programmable Pixel Clock Generator

This block derives a pixel-rate timing grid from the master clock. A counter walks through a period whose length in master clocks is two plus a 5-bit speed setting. It emits a one-cycle enable at the start of every period and a square-ish pixel clock level that is shifted against that enable by a programmable number of master clocks. Everything stays in the master clock domain: the pixel clock output is a registered-state-derived data signal, not a gated clock.

Speed and phase settings are sampled only at a period boundary, so a new setting never cuts a period short. Speeds above the legal ceiling of 21 are clamped to 21. Whenever the speed in force changes, a one-cycle change strobe is raised alongside the enable so downstream logic can mark the next frame as unreliable. A small controller has two states: `ST_BOOT`, the single cycle after reset in which the first settings are captured and all outputs are held low, and `ST_RUN`, the free-running state. The only transitions are reset into `ST_BOOT`, `ST_BOOT` to `ST_RUN` on the next edge, and `ST_RUN` to itself.

Top module: `pclk_gen`

## Requirements
- R1: While reset is asserted and during the first cycle after its release (`ST_BOOT`), `pix_en_o`, `pix_clk_o` and `chg_o` are all 0; in the next cycle `pix_en_o` is 1.
- R2: In `ST_RUN` the enable `pix_en_o` is high for exactly one master clock per period, and consecutive enables are 2 + speed master clocks apart, for every speed from 0 to 21.
- R3: A speed value from 22 to 31 behaves exactly like 21, giving a 23-clock period.
- R4: A speed written in the middle of a period does not change the length of that period; it applies from the next enable onward.
- R5: Within each period `pix_clk_o` is high for floor(P/2) master clocks and low for the rest, where P is the period length.
- R6: The rising edge of `pix_clk_o` falls (phase mod P) master clocks after the enable cycle; with a residue of 0 the clock is already high in the enable cycle. The phase is sampled at the same boundary as the speed.
- R7: `chg_o` is high for one master clock, in the enable cycle of the first period whose clamped speed differs from that of the preceding period (the value in force before the first period is 0).
- R8: `chg_o` stays low when a period starts with the same clamped speed as before, including a change only of phase or between two out-of-range speeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_i | input | 5 | Period setting; period = 2 + min(speed_i, 21) |
| phase_i | input | 4 | Pixel clock offset in master clocks, taken modulo the period |
| pix_en_o | output | 1 | One-cycle enable at the start of each pixel period |
| pix_clk_o | output | 1 | Phase-shifted pixel clock level |
| chg_o | output | 1 | One-cycle strobe when the speed in force changes |

## Verification
The bench builds the block with its default parameters: a 5-bit speed field, a 4-bit phase field, a ceiling of 21 and a base of 2. These values put every legal period from 2 to 23 in reach, together with the ten out-of-range codes that must clamp, and phase values both below and above the period, so the modulo wrap is exercised for short periods. A full sweep of all 22 legal speeds with random phases is followed by directed clamp, phase-only and mid-period changes and a random mix of in-range and out-of-range settings.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [0:0] {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } pclk_state_t;

    function automatic int unsigned per_width(input int unsigned max_per);
        return $clog2(max_per + 1);
    endfunction

endpackage

// File: rtl/pclk_clamp.sv
module pclk_clamp #(
    parameter int SPD_W   = 5,
    parameter int PH_W    = 4,
    parameter int SPD_MAX = 21,
    parameter int BASE    = 2,
    parameter int PER_W   = 5
) (
    input  logic [SPD_W-1:0] spd_i,
    input  logic [PH_W-1:0]  ph_i,
    output logic [SPD_W-1:0] spd_o,
    output logic [PER_W-1:0] per_o,
    output logic [PER_W-1:0] ph_o
);
    localparam int MW = (PER_W > PH_W) ? PER_W : PH_W;

    logic [MW-1:0] ph_mod;

    always_comb begin
        spd_o = (spd_i > SPD_W'(SPD_MAX)) ? SPD_W'(SPD_MAX) : spd_i;
        per_o = PER_W'(BASE) + PER_W'(spd_o);
        // residue of the requested offset within the new period
        ph_mod = MW'(ph_i) % MW'(per_o);
        ph_o   = ph_mod[PER_W-1:0];
    end
endmodule

// File: rtl/pclk_period_ctr.sv
module pclk_period_ctr #(
    parameter int PER_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PER_W-1:0] per_i,
    output logic [PER_W-1:0] cnt_o,
    output logic             wrap_o
);
    assign wrap_o = run_i && (cnt_o == per_i - PER_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (run_i) begin
            cnt_o <= wrap_o ? '0 : cnt_o + PER_W'(1);
        end
    end
endmodule

// File: rtl/pclk_wave.sv
module pclk_wave #(
    parameter int PER_W = 5
) (
    input  logic [PER_W-1:0] cnt_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [PER_W-1:0] ph_i,
    output logic             lvl_o
);
    logic [PER_W:0] pos;
    logic [PER_W:0] half;

    always_comb begin
        // position within the period, counted from the shifted rising edge
        pos   = {1'b0, cnt_i} - {1'b0, ph_i};
        if (cnt_i < ph_i) begin
            pos = pos + {1'b0, per_i};
        end
        half  = {1'b0, per_i} >> 1;
        lvl_o = (pos < half);
    end
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen
    import pclk_pkg::*;
#(
    parameter int SPD_W   = 5,
    parameter int PH_W    = 4,
    parameter int SPD_MAX = 21,
    parameter int BASE    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic             pix_en_o,
    output logic             pix_clk_o,
    output logic             chg_o
);
    localparam int PER_W = per_width(BASE + SPD_MAX);

    pclk_state_t      state_q, state_d;
    logic             load;
    logic             wrap;
    logic             lvl;
    logic             chg_q;
    logic             in_boot;
    logic [SPD_W-1:0] spd_new, cur_spd;
    logic [PER_W-1:0] per_new, cur_per;
    logic [PER_W-1:0] ph_new, cur_ph;
    logic [PER_W-1:0] cnt;

    pclk_clamp #(
        .SPD_W(SPD_W), .PH_W(PH_W), .SPD_MAX(SPD_MAX), .BASE(BASE), .PER_W(PER_W)
    ) u_clamp (
        .spd_i (speed_i),
        .ph_i  (phase_i),
        .spd_o (spd_new),
        .per_o (per_new),
        .ph_o  (ph_new)
    );

    pclk_period_ctr #(.PER_W(PER_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_RUN),
        .per_i  (cur_per),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    pclk_wave #(.PER_W(PER_W)) u_wave (
        .cnt_i (cnt),
        .per_i (cur_per),
        .ph_i  (cur_ph),
        .lvl_o (lvl)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    assign in_boot = (state_q == ST_BOOT);
    assign load    = in_boot || wrap;

    // settings in force, replaced only at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_spd <= '0;
            cur_per <= PER_W'(BASE);
            cur_ph  <= '0;
            chg_q   <= 1'b0;
        end else begin
            chg_q <= load && (spd_new != cur_spd);
            if (load) begin
                cur_spd <= spd_new;
                cur_per <= per_new;
                cur_ph  <= ph_new;
            end
        end
    end

    // outputs
    always_comb begin
        pix_en_o  = 1'b0;
        pix_clk_o = 1'b0;
        chg_o     = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                pix_en_o  = 1'b0;
                pix_clk_o = 1'b0;
                chg_o     = 1'b0;
            end
            ST_RUN: begin
                pix_en_o  = (cnt == '0);
                pix_clk_o = lvl;
                chg_o     = chg_q;
            end
            default: begin
                pix_en_o  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk #(
    parameter int SPD_W   = 5,
    parameter int SPD_MAX = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic             pix_clk,
    input logic             chg,
    input logic             in_boot,
    input logic             ph_zero,
    input logic [SPD_W-1:0] cur_spd
);
    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_boot |-> (!pix_en && !pix_clk && !chg)); // R1

    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |=> !pix_en); // R2

    AST_SPD_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        cur_spd <= SPD_W'(SPD_MAX)); // R3

    AST_SPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |-> $stable(cur_spd)); // R4

    AST_PH_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && ph_zero) |-> pix_clk); // R6

    AST_CHG_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> pix_en); // R7
endmodule

bind pclk_gen pclk_gen_chk #(
    .SPD_W(SPD_W), .SPD_MAX(SPD_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pix_en  (pix_en_o),
    .pix_clk (pix_clk_o),
    .chg     (chg_o),
    .in_boot (in_boot),
    .ph_zero (cur_ph == '0),
    .cur_spd (cur_spd)
);

// File: tb/pclk_gen_bench.sv
`timescale 1ns/1ps
module pclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] speed_i;
    logic [3:0] phase_i;
    logic       pix_en_o, pix_clk_o, chg_o;

    int n_run  = 0;
    int n_fail = 0;
    int prev_eff = 0;
    int cur_p = 2;

    always #2.5 clk = ~clk;

    pclk_gen u_pclk_gen (
        .clk(clk), .rst_n(rst_n), .speed_i(speed_i), .phase_i(phase_i),
        .pix_en_o(pix_en_o), .pix_clk_o(pix_clk_o), .chg_o(chg_o)
    );

    function automatic int eff_spd(input int s);
        return (s > 21) ? 21 : s;
    endfunction

    function automatic int per_of(input int s);
        return 2 + eff_spd(s);
    endfunction

    function automatic bit exp_lvl(input int k, input int p, input int ph);
        int pm = ph % p;
        int q  = (k - pm + p) % p;
        return q < (p / 2);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_en(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!pix_en_o && waited < 100);
    endtask

    // called at the negedge of an enable cycle that starts a period
    task automatic measure(input int spd, input int ph);
        int  p = per_of(spd);
        bit  lv[64];
        int  k = 0;
        int  hi = 0;
        int  rise = -1;
        int  bad = 0;
        do begin
            lv[k] = pix_clk_o;
            if (k < p && pix_clk_o != exp_lvl(k, p, ph)) bad++;
            if (pix_clk_o) hi++;
            @(negedge clk);
            k++;
        end while (!pix_en_o && k < 63);
        chk(k == p, (spd > 21) ? "R3" : "R2", "period", k, p);
        chk(hi == p / 2, "R5", "high cycles", hi, p / 2);
        if (k == p) begin
            for (int j = p - 1; j >= 0; j--)
                if (lv[j] && !lv[(j + p - 1) % p]) rise = j;
        end
        chk(bad == 0 && rise == ph % p, "R6", "rise offset", rise, ph % p);
        cur_p = p;
    endtask

    task automatic chg_check(input int spd);
        bit exp = (eff_spd(spd) != prev_eff);
        chk(chg_o == exp, exp ? "R7" : "R8", "change strobe", chg_o, exp);
        prev_eff = eff_spd(spd);
    endtask

    task automatic run_case(input int spd, input int ph);
        int w;
        speed_i = 5'(spd);
        phase_i = 4'(ph);
        wait_en(w);
        chg_check(spd);
        measure(spd, ph);
    endtask

    task automatic mid_change(input int spd, input int ph);
        int w;
        int old_p = cur_p;
        @(negedge clk);
        speed_i = 5'(spd);
        phase_i = 4'(ph);
        wait_en(w);
        chk(w == old_p - 1, "R4", "remaining old period", w + 1, old_p);
        chg_check(spd);
        measure(spd, ph);
    endtask

    initial begin
        #(5.0 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n   = 1'b0;
        speed_i = 5'd9;
        phase_i = 4'd3;
        repeat (3) @(negedge clk);
        chk(!pix_en_o && !pix_clk_o && !chg_o, "R1", "outputs in reset",
            {pix_en_o, pix_clk_o, chg_o}, 0);
        speed_i = 5'd0;
        phase_i = 4'd0;
        rst_n   = 1'b1;
        #1;
        chk(!pix_en_o && !pix_clk_o && !chg_o, "R1", "outputs in boot cycle",
            {pix_en_o, pix_clk_o, chg_o}, 0);
        @(negedge clk);
        chk(pix_en_o == 1'b1, "R1", "first enable", pix_en_o, 1);
        chg_check(0);
        measure(0, 0);

        // every legal speed with a random phase
        for (int s = 0; s <= 21; s++) run_case(s, int'($urandom % 16));

        // out-of-range codes clamp to the ceiling
        run_case(31, 5);
        run_case(25, 15);
        run_case(22, 0);
        // phase-only change keeps the strobe low
        run_case(21, 9);
        run_case(3, 2);
        run_case(3, 14);
        run_case(0, 15);
        run_case(0, 1);

        // mid-period changes
        mid_change(17, 6);
        mid_change(1, 11);
        mid_change(28, 4);
        mid_change(0, 7);

        // random mix
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 4 == 0) mid_change(int'($urandom % 32), int'($urandom % 16));
            else                   run_case(int'($urandom % 32), int'($urandom % 16));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule